// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This controller sits next to the program counter of a simple instruction sequencer and runs counted or flag-terminated loops without spending any cycle on branch, compare or decrement instructions. Software first writes an iteration count into a staging counter register. It then issues a loop-start command that names the address of the last instruction of the body and a termination condition. The body begins at the instruction right after the loop-start command.

While a loop is open, the controller compares every fetch address with the end address of the innermost loop. At that address it evaluates the termination condition in the same cycle. If the condition is false, it selects the loop start as the next PC. If the condition is true, it lets the sequencer fall through to the end address plus one and closes the loop. Four loops may be nested. A loop-start command is rejected with a one-cycle error pulse when the nesting store is full or when the body is shorter than three instructions.

Top module: `hwloop_ctrl`

## Requirements
- R1: `lc_wr` loads `lc_val` into the staging count register at the clock edge. A loop-start command captures the staging value, or `lc_val` itself when `lc_wr` is high in the same cycle.
- R2: An accepted loop-start command (`do_valid` high) records start = `fetch_pc`+1, end = `do_end`, the count from R1 and the condition `do_cond`. From the next cycle `loop_active` is 1 and `pc_target` shows that start address.
- R3: When `fetch_pc` equals the innermost end address and the termination condition is false, `pc_sel` is 1 in that same cycle and `pc_target` holds the loop start. At every other address `pc_sel` is 0.
- R4: Condition code 0 selects counter-expired, which is true when the entry's count is 1 or less. The count drops by one on each branch back, so a count of N runs the body N times, and a count of 0 runs it once.
- R5: Condition codes 1, 2 and 3 end the loop when `flags[0]` (equal), `flags[1]` (greater) or `flags[2]` (less), respectively, is 1 at the end-address fetch. The other flag bits have no effect.
- R6: When the condition is true at the end address, `loop_done` is 1 and `pc_sel` is 0 in that cycle. The innermost entry is removed at the edge, and the enclosing loop becomes the active one.
- R7: Up to four loops nest. Only the innermost one is checked against the fetch address, and an outer loop resumes once an inner one closes.
- R8: A loop-start command while four loops are open is not recorded, and `ovf_err` is 1 for the following cycle only.
- R9: A loop-start command with `do_end` − `fetch_pc` < 3 (including `do_end` ≤ `fetch_pc`) is not recorded, and `short_err` is 1 for the following cycle only.
- R10: In a cycle where `do_valid` is 1, no end-address test is made: `pc_sel` and `loop_done` stay 0 and no entry is removed.
- R11: A synchronous `rst` clears all entries, the staging count and both error flags. `loop_active` is 0 in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lc_wr | input | 1 | Write strobe for the staging count register |
| lc_val | input | CW | Iteration count to load |
| do_valid | input | 1 | Loop-start command executes in this cycle |
| do_end | input | AW | Address of the last body instruction |
| do_cond | input | 2 | Termination select: 0 count, 1 equal, 2 greater, 3 less |
| fetch_pc | input | AW | Address fetched in this cycle |
| flags | input | 3 | Status flags: bit0 equal, bit1 greater, bit2 less |
| pc_sel | output | 1 | Next PC comes from `pc_target` instead of PC+1 |
| pc_target | output | AW | Innermost loop start address (0 when idle) |
| loop_active | output | 1 | At least one loop is open |
| loop_done | output | 1 | Innermost loop finishes at this fetch |
| ovf_err | output | 1 | Previous loop-start command was refused: store full |
| short_err | output | 1 | Previous loop-start command was refused: body too short |

## Verification
`pc_sel`, `pc_target` and `loop_done` depend combinationally on `fetch_pc` and the flags, so they are due in the same cycle as the fetch they answer. `loop_active`, the error pulses and the stored counts change only at the next rising edge. The bench drives each cycle's inputs at the falling edge and compares all six outputs with its behavioural model shortly afterwards, before the rising edge. The model's state then advances as the edge would advance it. The bench steers its own fetch address from the model's redirect decision, and it counts how many times each body address is fetched to confirm the iteration counts.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic [1:0] {
        TERM_COUNT = 2'd0,
        TERM_EQ    = 2'd1,
        TERM_GT    = 2'd2,
        TERM_LT    = 2'd3
    } term_sel_e;

    localparam int NFLAG   = 3;
    localparam int FLAG_EQ = 0;
    localparam int FLAG_GT = 1;
    localparam int FLAG_LT = 2;

endpackage

// File: rtl/hwloop_cond.sv
module hwloop_cond
    import hwloop_pkg::*;
#(
    parameter int CW = 16
) (
    input  term_sel_e          sel,
    input  logic [NFLAG-1:0]   flags,
    input  logic [CW-1:0]      count,
    output logic               cond_met
);

    always_comb begin
        unique case (sel)
            TERM_COUNT: cond_met = (count <= CW'(1));
            TERM_EQ:    cond_met = flags[FLAG_EQ];
            TERM_GT:    cond_met = flags[FLAG_GT];
            TERM_LT:    cond_met = flags[FLAG_LT];
            default:    cond_met = 1'b1;
        endcase
    end

endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
    parameter int W     = 34,
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic [W-1:0]                push_data,
    input  logic                        pop,
    input  logic                        upd,
    input  logic [W-1:0]                upd_data,
    output logic [W-1:0]                top_data,
    output logic [$clog2(DEPTH+1)-1:0]  depth,
    output logic                        full,
    output logic                        empty
);

    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNTW-1:0]         cnt;
    } stk_t;

    stk_t s_d, s_q;
    logic [PW-1:0] top_idx, wr_idx;

    assign top_idx = PW'(s_q.cnt - CNTW'(1));
    assign wr_idx  = PW'(s_q.cnt);
    assign full    = (s_q.cnt == CNTW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign depth   = s_q.cnt;
    assign top_data = empty ? '0 : s_q.mem[top_idx];

    always_comb begin
        s_d = s_q;
        if (push && !full) begin
            s_d.mem[wr_idx] = push_data;
            s_d.cnt         = s_q.cnt + CNTW'(1);
        end else if (pop && !empty) begin
            s_d.cnt = s_q.cnt - CNTW'(1);
        end else if (upd && !empty) begin
            s_d.mem[top_idx] = upd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R8: the controller never pushes into a full store
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R6: removal only happens with an open loop
    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R7: nesting depth moves by at most one per cycle
    a_r7_depth_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((s_q.cnt == $past(s_q.cnt)) ||
                  (s_q.cnt == $past(s_q.cnt) + CNTW'(1)) ||
                  (s_q.cnt == $past(s_q.cnt) - CNTW'(1))));

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CW       = 16,
    parameter int DEPTH    = 4,
    parameter int MIN_BODY = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lc_wr,
    input  logic [CW-1:0] lc_val,
    input  logic          do_valid,
    input  logic [AW-1:0] do_end,
    input  logic [1:0]    do_cond,
    input  logic [AW-1:0] fetch_pc,
    input  logic [2:0]    flags,
    output logic          pc_sel,
    output logic [AW-1:0] pc_target,
    output logic          loop_active,
    output logic          loop_done,
    output logic          ovf_err,
    output logic          short_err
);

    localparam int DW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] fin;
        logic [CW-1:0] cnt;
        term_sel_e     sel;
    } ent_t;

    localparam int EW = $bits(ent_t);

    typedef struct packed {
        logic [CW-1:0] lc;
        logic          ovf;
        logic          shrt;
    } ctl_t;

    ctl_t          st_d, st_q;
    ent_t          top_ent, push_ent, upd_ent;
    logic [EW-1:0] top_raw;
    logic [DW-1:0] stk_depth;
    logic          stk_full, stk_empty;
    logic          cond_met, at_end, too_short, do_accept;
    logic          pop_req, upd_req;
    logic [AW-1:0] body_span;
    logic [CW-1:0] cnt_src;

    assign top_ent = ent_t'(top_raw);

    hwloop_cond #(.CW(CW)) u_cond (
        .sel      (top_ent.sel),
        .flags    (flags),
        .count    (top_ent.cnt),
        .cond_met (cond_met)
    );

    always_comb begin
        st_d = st_q;

        cnt_src = lc_wr ? lc_val : st_q.lc;
        if (lc_wr) st_d.lc = lc_val;

        at_end    = !stk_empty && !do_valid && (fetch_pc == top_ent.fin);
        pc_sel    = at_end && !cond_met;
        loop_done = at_end && cond_met;
        pc_target = stk_empty ? '0 : top_ent.start;

        pop_req = loop_done;
        upd_req = pc_sel && (top_ent.sel == TERM_COUNT);
        upd_ent     = top_ent;
        upd_ent.cnt = top_ent.cnt - CW'(1);

        body_span = do_end - fetch_pc;
        too_short = (do_end <= fetch_pc) || (body_span < AW'(MIN_BODY));
        do_accept = do_valid && !stk_full && !too_short;

        push_ent.start = fetch_pc + AW'(1);
        push_ent.fin   = do_end;
        push_ent.cnt   = cnt_src;
        push_ent.sel   = term_sel_e'(do_cond);

        st_d.ovf  = do_valid && stk_full;
        st_d.shrt = do_valid && too_short;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    hwloop_stack #(.W(EW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (do_accept),
        .push_data (push_ent),
        .pop       (pop_req),
        .upd       (upd_req),
        .upd_data  (upd_ent),
        .top_data  (top_raw),
        .depth     (stk_depth),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    assign loop_active = !stk_empty;
    assign ovf_err     = st_q.ovf;
    assign short_err   = st_q.shrt;

    // R2: an accepted command exposes the following address as the loop start
    a_r2_start_latched: assert property (@(posedge clk) disable iff (rst)
        do_accept |=> (loop_active && pc_target == $past(fetch_pc) + AW'(1)));

    // R4: each counted branch back lowers the stored count by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (pc_sel && top_ent.sel == TERM_COUNT) |=> (top_ent.cnt == $past(top_ent.cnt) - CW'(1)));

    // R6: a finished loop leaves the store one entry shallower
    a_r6_close_pops: assert property (@(posedge clk) disable iff (rst)
        loop_done |=> (stk_depth == $past(stk_depth) - DW'(1)));

    // R8: a refused command for a full store flags and leaves depth alone
    a_r8_overflow: assert property (@(posedge clk) disable iff (rst)
        (do_valid && stk_full) |=> (ovf_err && $stable(stk_depth)));

    // R9: a refused short body flags and leaves depth alone
    a_r9_short_body: assert property (@(posedge clk) disable iff (rst)
        (do_valid && too_short) |=> (short_err && $stable(stk_depth)));

    // R10: no redirect or close while a loop-start command executes
    a_r10_do_masks_end: assert property (@(posedge clk) disable iff (rst)
        do_valid |-> (!pc_sel && !loop_done));

    // R11: reset leaves no open loop and no error pulse
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!loop_active && !ovf_err && !short_err));

endmodule

// File: tb/tb_hwloop_ctrl.sv
module tb_hwloop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int PSZ = 128;

    logic          clk = 1'b0;
    logic          rst;
    logic          lc_wr;
    logic [CW-1:0] lc_val;
    logic          do_valid;
    logic [AW-1:0] do_end;
    logic [1:0]    do_cond;
    logic [AW-1:0] fetch_pc;
    logic [2:0]    flags;
    logic          pc_sel;
    logic [AW-1:0] pc_target;
    logic          loop_active, loop_done, ovf_err, short_err;

    hwloop_ctrl dut (
        .clk(clk), .rst(rst), .lc_wr(lc_wr), .lc_val(lc_val),
        .do_valid(do_valid), .do_end(do_end), .do_cond(do_cond),
        .fetch_pc(fetch_pc), .flags(flags), .pc_sel(pc_sel),
        .pc_target(pc_target), .loop_active(loop_active),
        .loop_done(loop_done), .ovf_err(ovf_err), .short_err(short_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference state
    int q_start[$], q_end[$], q_cond[$], q_cnt[$];
    int lc_m = 0;
    bit ovf_m = 0, short_m = 0;
    bit exp_sel;
    int exp_tgt;

    // program description indexed by address
    int p_end[PSZ], p_cond[PSZ], p_lc[PSZ];
    int hits[PSZ];
    int fl_code = 0, fl_k = 0, fl_addr = 0;
    int ovf_seen = 0, short_seen = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PSZ; i++) begin
            p_end[i] = -1; p_cond[i] = 0; p_lc[i] = -1; hits[i] = 0;
        end
        ovf_seen = 0; short_seen = 0;
    endtask

    // Evaluate one cycle: inputs already driven at the falling edge.
    task automatic step();
        bit at_end, ct, fullm, shortm;
        int sel, cnt, src;
        #2;
        if (rst) begin
            q_start.delete(); q_end.delete(); q_cond.delete(); q_cnt.delete();
            lc_m = 0; ovf_m = 0; short_m = 0; exp_sel = 0; exp_tgt = 0;
            return;
        end
        sel = (q_cond.size() > 0) ? q_cond[$] : 0;
        cnt = (q_cnt.size() > 0) ? q_cnt[$] : 0;
        at_end = (q_end.size() > 0) && !do_valid && (int'(fetch_pc) == q_end[$]);
        ct = (sel == 0) ? (cnt <= 1) : flags[sel-1];
        exp_sel = at_end && !ct;
        exp_tgt = (q_start.size() > 0) ? q_start[$] : 0;

        check(pc_sel == exp_sel, "R3", "pc_sel", int'(pc_sel), int'(exp_sel));
        check(int'(pc_target) == exp_tgt, "R2", "pc_target", int'(pc_target), exp_tgt);
        check(loop_done == (at_end && ct), "R6", "loop_done", int'(loop_done), int'(at_end && ct));
        check(loop_active == (q_start.size() > 0), "R7", "loop_active",
              int'(loop_active), int'(q_start.size() > 0));
        check(ovf_err == ovf_m, "R8", "ovf_err", int'(ovf_err), int'(ovf_m));
        check(short_err == short_m, "R9", "short_err", int'(short_err), int'(short_m));
        if (ovf_err) ovf_seen++;
        if (short_err) short_seen++;

        // advance as the rising edge would
        if (at_end && ct) begin
            void'(q_start.pop_back()); void'(q_end.pop_back());
            void'(q_cond.pop_back()); void'(q_cnt.pop_back());
        end else if (exp_sel && sel == 0) begin
            q_cnt[q_cnt.size()-1] = cnt - 1;
        end
        src = lc_wr ? int'(lc_val) : lc_m;
        if (lc_wr) lc_m = int'(lc_val);
        fullm  = (q_start.size() == 4);
        shortm = (int'(do_end) <= int'(fetch_pc)) || (int'(do_end) - int'(fetch_pc) < 3);
        ovf_m   = do_valid && fullm;
        short_m = do_valid && shortm;
        if (do_valid && !fullm && !shortm) begin
            q_start.push_back(int'(fetch_pc) + 1);
            q_end.push_back(int'(do_end));
            q_cond.push_back(int'(do_cond));
            q_cnt.push_back(src);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lc_wr = 0; do_valid = 0; fetch_pc = AW'(PSZ - 1); flags = 3'b000;
            step();
        end
    endtask

    task automatic run(input int start_pc, input int halt_pc);
        int pc = start_pc;
        int guard = 0;
        while (pc != halt_pc && guard < 20000) begin
            logic [2:0] sb;
            guard++;
            @(negedge clk);
            fetch_pc = AW'(pc);
            hits[pc]++;
            lc_wr    = (p_lc[pc] >= 0);
            lc_val   = (p_lc[pc] >= 0) ? CW'(p_lc[pc]) : '0;
            do_valid = (p_end[pc] >= 0);
            do_end   = (p_end[pc] >= 0) ? AW'(p_end[pc]) : '0;
            do_cond  = 2'(p_cond[pc]);
            if (fl_code == 0) flags = 3'b000;
            else begin
                sb = 3'(1 << (fl_code - 1));
                flags = (hits[fl_addr] >= fl_k) ? sb : (~sb & 3'b111);
            end
            step();
            pc = exp_sel ? exp_tgt : pc + 1;
        end
        check(guard < 20000, "R3", "run reached halt", guard, 0);
        idle(1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; lc_wr = 0; lc_val = '0; do_valid = 0; do_end = '0;
        do_cond = '0; fetch_pc = '0; flags = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); step();
        end
        @(negedge clk); rst = 0; step();
        idle(1);
        check(!loop_active && !ovf_err && !short_err && !pc_sel, "R11", "reset state",
              int'(loop_active), 0);

        // counted loop, 30 passes over a three-instruction body
        clear_prog(); p_lc[0] = 30; p_end[1] = 4;
        run(0, 5);
        check(hits[2] == 30, "R4", "30-pass body count", hits[2], 30);
        check(hits[4] == 30, "R3", "end fetched per pass", hits[4], 30);

        // count written in the same cycle as the loop-start command
        clear_prog(); p_lc[10] = 5; p_end[10] = 13;
        run(10, 14);
        check(hits[11] == 5, "R1", "same-cycle count", hits[11], 5);

        // count zero and one each give one pass
        clear_prog(); p_lc[15] = 0; p_end[16] = 19;
        run(15, 20);
        check(hits[17] == 1, "R4", "count 0 passes", hits[17], 1);
        clear_prog(); p_lc[21] = 1; p_end[22] = 25;
        run(21, 26);
        check(hits[23] == 1, "R4", "count 1 passes", hits[23], 1);

        // flag-terminated loops; unselected flags held high meanwhile
        for (int code = 1; code <= 3; code++) begin
            clear_prog(); p_end[30] = 33; p_cond[30] = code;
            fl_code = code; fl_k = code + 2; fl_addr = 31;
            run(30, 34);
            check(hits[31] == code + 2, "R5", "flag loop passes", hits[31], code + 2);
        end
        fl_code = 0;

        // two-level nesting
        clear_prog(); p_lc[40] = 3; p_end[41] = 50; p_lc[42] = 2; p_end[43] = 46;
        run(40, 51);
        check(hits[42] == 3, "R7", "outer passes", hits[42], 3);
        check(hits[44] == 6, "R7", "inner passes", hits[44], 6);

        // fifth nested command is refused
        clear_prog(); p_lc[60] = 1;
        p_end[61] = 80; p_end[62] = 79; p_end[63] = 78; p_end[64] = 77; p_end[65] = 76;
        run(60, 81);
        check(ovf_seen == 1, "R8", "overflow pulses", ovf_seen, 1);
        check(hits[66] == 1, "R8", "refused loop not run", hits[66], 1);

        // short bodies refused, minimal three-instruction body accepted
        clear_prog(); p_end[85] = 86; p_end[87] = 89; p_end[90] = 90; p_end[91] = 88;
        p_lc[92] = 2; p_end[92] = 95;
        run(85, 96);
        check(short_seen == 4, "R9", "short pulses", short_seen, 4);
        check(hits[93] == 2, "R9", "three-instr body passes", hits[93], 2);

        // loop-start command sitting on an active end address
        clear_prog(); p_lc[100] = 2; p_end[100] = 103; p_end[103] = 107;
        run(100, 108);
        check(hits[101] == 1, "R10", "no branch back on command cycle", hits[101], 1);
        check(hits[104] == 2, "R10", "new loop runs", hits[104], 2);
        check(loop_active == 1'b1, "R10", "outer entry kept", int'(loop_active), 1);

        // reset in the middle of an open loop
        @(negedge clk); rst = 1; step();
        @(negedge clk); rst = 0; step();
        check(loop_active == 1'b0 && int'(pc_target) == 0, "R11", "mid-run reset",
              int'(loop_active), 0);
        idle(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule